// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is a small programmable logic core of the AND-OR kind. A wide configuration vector, held steady while the core runs, describes every product term of an AND plane. The plane sees eleven dedicated logic inputs and ten feedback signals, each in true and complemented form. The same vector sets up ten output macrocells. Each macrocell ORs its own group of product terms. A further term per macrocell drives the pin enable, and two shared terms drive a common register preset and a common register clear.

Every macrocell decides for itself whether its pin shows the OR result directly or through a flip-flop, and whether that value is inverted. Its enable term decides whether it drives its pin. A pin whose enable is low can be used as an input to the plane. The pad is modelled as three plain ports per pin: the value driven out, the enable, and the value seen on the pad. An external tri-state buffer joins them.

Top module: `pal_sop_core`

## Requirements
- R1: A product term is the AND of the literals whose mask bit is 1. Signal k owns mask bit 2k (true literal) and bit 2k+1 (complemented literal). Signals 0..10 are `in_i[0..10]` and signals 11..20 are the feedback of macrocells 0..9. A term with an all-zero mask is true. Term t occupies `cfg_bits[t*42 +: 42]`.
- R2: Macrocell j ORs its own group of product terms. The group sizes for j = 0..9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. Macrocell j uses one enable term and then its sum terms, in that order, placed after those of macrocell j-1. The terms at indices 130 and 131 are the clear term and the preset term.
- R3: In combinational mode, `pin_out[j]` follows the OR result in the same cycle, with no clock edge.
- R4: In registered mode, the flip-flop loads the OR result on the rising clock edge, and `pin_out[j]` changes only after that edge.
- R5: The invert bit `cfg_bits[5544+2j+1]` set to 1 makes `pin_out[j]` the complement of the combinational or registered value. The mode bit `cfg_bits[5544+2j]` set to 1 selects registered mode.
- R6: `pin_oe[j]` equals macrocell j's enable product term in the same cycle.
- R7: Feedback of macrocell j is its flip-flop state in registered mode and `pin_in[j]` in combinational mode. In registered mode, `pin_in[j]` has no effect on the plane.
- R8: While the preset term is true at a rising edge, every flip-flop is set to 1 at that edge.
- R9: While the clear term is true, every flip-flop is 0 at once, with no clock edge needed.
- R10: When the clear and preset terms are both true, the flip-flops stay 0.
- R11: `rst` high at a rising edge clears every flip-flop, and rst takes priority over the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the macrocell flip-flops |
| rst | input | 1 | Synchronous active-high reset of the flip-flops |
| cfg_bits | input | 5564 | Product term masks followed by two mode bits per macrocell |
| in_i | input | 11 | Dedicated logic inputs to the plane |
| pin_in | input | 10 | Value seen on each pad |
| pin_out | output | 10 | Value each macrocell would drive |
| pin_oe | output | 10 | Drive enable of each pad |

## Verification
Combinational results, meaning the pin value in combinational mode, the enables and the feedback paths, are due in the same cycle as their inputs. The bench drives at the falling edge and checks one nanosecond later. Registered results are due one rising edge after their cause, so the bench first checks that the pin is unchanged before the edge, then checks the new value one nanosecond after it. The clear term needs no edge. It is raised between edges and checked before the next rising edge, and it is then held across that edge to show that it wins over the preset.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;

  // Mode bits of one macrocell, LSB = register select, MSB = invert
  typedef struct packed {
    logic invert;
    logic reg_mode;
  } mc_cfg_t;

  // Sum-term group size: grows from both ends toward the middle
  function automatic int sum_size(int j, int npin, int tmin, int tstep);
    int d;
    d = (j < npin - 1 - j) ? j : (npin - 1 - j);
    return tmin + tstep * d;
  endfunction

  // Index of the enable term of macrocell j (its sum terms follow it)
  function automatic int oe_index(int j, int npin, int tmin, int tstep);
    int acc;
    acc = 0;
    for (int i = 0; i < j; i++) acc += 1 + sum_size(i, npin, tmin, tstep);
    return acc;
  endfunction

  // All macrocell terms plus the shared clear and preset terms
  function automatic int term_total(int npin, int tmin, int tstep);
    return oe_index(npin, npin, tmin, tstep) + 2;
  endfunction

endpackage

// File: rtl/pal_literal_gen.sv
module pal_literal_gen #(
  parameter int NSIG = 21,
  localparam int NLIT = 2 * NSIG
) (
  input  logic [NSIG-1:0] sig,
  output logic [NLIT-1:0] lit
);

  // Even position: true literal; odd position: complement
  for (genvar k = 0; k < NSIG; k++) begin : g_lit
    assign lit[2*k]     = sig[k];
    assign lit[2*k + 1] = ~sig[k];
  end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int NLIT  = 42,
  parameter int NTERM = 132
) (
  input  logic [NLIT-1:0]       lit,
  input  logic [NTERM*NLIT-1:0] mask,
  output logic [NTERM-1:0]      term
);

  // Unconnected literals are forced to 1, so an empty mask yields a true term
  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign term[t] = &(lit | ~mask[t*NLIT +: NLIT]);
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_sop_pkg::*;
#(
  parameter int NT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_term,
  input  logic          set_term,
  input  logic [NT-1:0] sum_terms,
  input  logic          oe_term,
  input  mc_cfg_t       mode,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          fb,
  output logic          q_o,
  output logic          sum_o
);

  logic sum;
  logic q;
  logic level;

  assign sum = |sum_terms;

  // Shared clear acts without the clock and outranks everything else
  always_ff @(posedge clk or posedge clr_term) begin
    if (clr_term)      q <= 1'b0;
    else if (rst)      q <= 1'b0;
    else if (set_term) q <= 1'b1;
    else               q <= sum;
  end

  assign level   = mode.reg_mode ? q : sum;
  assign pin_out = level ^ mode.invert;
  assign pin_oe  = oe_term;
  assign fb      = mode.reg_mode ? q : pin_in;
  assign q_o     = q;
  assign sum_o   = sum;

endmodule

// File: rtl/pal_sop_core.sv
module pal_sop_core
  import pal_sop_pkg::*;
#(
  parameter int  NIN   = 11,
  parameter int  NPIN  = 10,
  parameter int  TMIN  = 8,
  parameter int  TSTEP = 2,
  localparam int NSIG  = NIN + NPIN,
  localparam int NLIT  = 2 * NSIG,
  localparam int NTERM = term_total(NPIN, TMIN, TSTEP),
  localparam int MASKW = NTERM * NLIT,
  localparam int CFGW  = MASKW + 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CFGW-1:0] cfg_bits,
  input  logic [NIN-1:0]  in_i,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  logic [NPIN-1:0]  fb_vec;
  logic [NPIN-1:0]  reg_q;
  logic [NPIN-1:0]  sum_vec;
  logic [NSIG-1:0]  sig;
  logic [NLIT-1:0]  lit;
  logic [NTERM-1:0] term;
  logic             ar_term;
  logic             sp_term;

  assign sig = {fb_vec, in_i};

  pal_literal_gen #(.NSIG(NSIG)) u_lit (
    .sig (sig),
    .lit (lit)
  );

  pal_and_plane #(.NLIT(NLIT), .NTERM(NTERM)) u_plane (
    .lit  (lit),
    .mask (cfg_bits[MASKW-1:0]),
    .term (term)
  );

  assign ar_term = term[NTERM-2];
  assign sp_term = term[NTERM-1];

  for (genvar j = 0; j < NPIN; j++) begin : g_mc
    localparam int NT   = sum_size(j, NPIN, TMIN, TSTEP);
    localparam int OEIX = oe_index(j, NPIN, TMIN, TSTEP);
    mc_cfg_t mode;
    assign mode = cfg_bits[MASKW + 2*j +: 2];

    pal_macrocell #(.NT(NT)) u_mc (
      .clk       (clk),
      .rst       (rst),
      .clr_term  (ar_term),
      .set_term  (sp_term),
      .sum_terms (term[OEIX + 1 +: NT]),
      .oe_term   (term[OEIX]),
      .mode      (mode),
      .pin_in    (pin_in[j]),
      .pin_out   (pin_out[j]),
      .pin_oe    (pin_oe[j]),
      .fb        (fb_vec[j]),
      .q_o       (reg_q[j]),
      .sum_o     (sum_vec[j])
    );
  end

endmodule

// File: rtl/pal_sop_core_chk.sv
module pal_sop_core_chk #(
  parameter int NPIN = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            ar,
  input logic            sp,
  input logic [NPIN-1:0] q,
  input logic [NPIN-1:0] sum
);

  AST_REG_LOADS_SUM: assert property (@(posedge clk) disable iff (rst)
    (!ar && !sp) |=> (ar || q == $past(sum))); // R4

  AST_PRESET_SETS_ALL: assert property (@(posedge clk) disable iff (rst)
    (sp && !ar) |=> (ar || q == '1)); // R8

  AST_CLEAR_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    ar |-> q == '0); // R9

  AST_CLEAR_BEATS_PRESET: assert property (@(posedge clk) disable iff (rst)
    (ar && sp) |-> q == '0); // R10

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> q == '0); // R11

endmodule

bind pal_sop_core pal_sop_core_chk #(.NPIN(NPIN)) u_chk (
  .clk (clk),
  .rst (rst),
  .ar  (ar_term),
  .sp  (sp_term),
  .q   (reg_q),
  .sum (sum_vec)
);

// File: tb/test_pal_sop_core.sv
module test_pal_sop_core;

  localparam int NIN  = 11;
  localparam int NPIN = 10;
  localparam int L    = 2 * (NIN + NPIN);
  localparam int TT   = 132;
  localparam int MBASE = TT * L;
  localparam int CFGW = MBASE + 2 * NPIN;
  localparam int AR_T = TT - 2;
  localparam int SP_T = TT - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CFGW-1:0] cfg = '0;
  logic [NIN-1:0]  in_i = '0;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out;
  logic [NPIN-1:0] pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pal_sop_core i_pal_sop_core (
    .clk      (clk),
    .rst      (rst),
    .cfg_bits (cfg),
    .in_i     (in_i),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  function automatic int nt(int j);
    return 8 + 2 * ((j < NPIN - 1 - j) ? j : NPIN - 1 - j);
  endfunction

  function automatic int oe_idx(int j);
    int s;
    s = 0;
    for (int i = 0; i < j; i++) s += 1 + nt(i);
    return s;
  endfunction

  function automatic int sum_idx(int j, int i);
    return oe_idx(j) + 1 + i;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_term(int t);
    for (int b = 0; b < L; b++) cfg[t*L + b] = 1'b0;
  endtask

  task automatic kill_term(int t);
    clear_term(t);
    cfg[t*L]     = 1'b1;
    cfg[t*L + 1] = 1'b1;
  endtask

  task automatic lit(int t, int k, bit neg);
    cfg[t*L + 2*k + int'(neg)] = 1'b1;
  endtask

  task automatic set_mode(int j, bit regm, bit inv);
    cfg[MBASE + 2*j]     = regm;
    cfg[MBASE + 2*j + 1] = inv;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    for (int t = 0; t < TT; t++) kill_term(t);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 reset pin_out", 32'(pin_out), 32'h0);
    chk("R6 reset pin_oe", 32'(pin_oe), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_and_term();
    @(negedge clk);
    clear_term(oe_idx(0));
    clear_term(sum_idx(0, 0));
    lit(sum_idx(0, 0), 0, 1'b0);
    lit(sum_idx(0, 0), 1, 1'b1);
    clear_term(sum_idx(1, 0));
    for (int p = 0; p < 4; p++) begin
      in_i[0] = p[0];
      in_i[1] = p[1];
      #1;
      chk("R1 and of in0 and not in1", 32'(pin_out[0]), 32'(p[0] & ~p[1]));
      chk("R3 comb output enable on", 32'(pin_oe[0]), 32'h1);
    end
    chk("R1 empty term is true", 32'(pin_out[1]), 32'h1);
    in_i[1:0] = 2'b00;
  endtask

  task automatic t_sum_size();
    @(negedge clk);
    clear_term(sum_idx(4, 15));
    lit(sum_idx(4, 15), 2, 1'b0);
    clear_term(sum_idx(0, 7));
    lit(sum_idx(0, 7), 3, 1'b0);
    in_i[2] = 1'b1;
    #1;
    chk("R2 last of 16 terms", 32'(pin_out[4]), 32'h1);
    in_i[2] = 1'b0;
    #1;
    chk("R2 last of 16 terms low", 32'(pin_out[4]), 32'h0);
    in_i[3] = 1'b1;
    #1;
    chk("R2 last of 8 terms", 32'(pin_out[0]), 32'h1);
    in_i[3] = 1'b0;
    #1;
    chk("R2 last of 8 terms low", 32'(pin_out[0]), 32'h0);
  endtask

  task automatic t_polarity();
    @(negedge clk);
    set_mode(2, 1'b0, 1'b1);
    clear_term(sum_idx(2, 0));
    lit(sum_idx(2, 0), 4, 1'b0);
    for (int v = 0; v < 2; v++) begin
      in_i[4] = v[0];
      #1;
      chk("R5 inverted comb output", 32'(pin_out[2]), 32'(~v[0] & 1'b1));
    end
    in_i[4] = 1'b0;
  endtask

  task automatic t_oe();
    @(negedge clk);
    clear_term(oe_idx(3));
    lit(oe_idx(3), 5, 1'b0);
    for (int v = 0; v < 2; v++) begin
      in_i[5] = v[0];
      #1;
      chk("R6 enable follows its term", 32'(pin_oe[3]), 32'(v[0]));
    end
    in_i[5] = 1'b0;
  endtask

  task automatic t_registered();
    @(negedge clk);
    set_mode(5, 1'b1, 1'b0);
    clear_term(sum_idx(5, 0));
    lit(sum_idx(5, 0), 6, 1'b0);
    in_i[6] = 1'b1;
    #1;
    chk("R4 no change before edge", 32'(pin_out[5]), 32'h0);
    after_edge();
    chk("R4 loaded at edge", 32'(pin_out[5]), 32'h1);
    @(negedge clk);
    in_i[6] = 1'b0;
    #1;
    chk("R4 held until edge", 32'(pin_out[5]), 32'h1);
    after_edge();
    chk("R4 cleared at edge", 32'(pin_out[5]), 32'h0);
  endtask

  task automatic t_feedback();
    @(negedge clk);
    clear_term(sum_idx(6, 0));
    lit(sum_idx(6, 0), NIN + 5, 1'b0);
    clear_term(sum_idx(7, 0));
    lit(sum_idx(7, 0), NIN + 8, 1'b0);
    in_i[6] = 1'b1;
    pin_in[5] = 1'b0;
    after_edge();
    chk("R7 registered feedback uses state", 32'(pin_out[6]), 32'h1);
    @(negedge clk);
    pin_in[8] = 1'b1;
    #1;
    chk("R7 comb feedback uses pad", 32'(pin_out[7]), 32'h1);
    pin_in[8] = 1'b0;
    #1;
    chk("R7 comb feedback uses pad low", 32'(pin_out[7]), 32'h0);
    pin_in[5] = 1'b1;
    in_i[6] = 1'b0;
    after_edge();
    chk("R7 pad ignored in registered mode", 32'(pin_out[6]), 32'h0);
    pin_in[5] = 1'b0;
  endtask

  task automatic t_preset();
    @(negedge clk);
    set_mode(9, 1'b1, 1'b1);
    clear_term(SP_T);
    lit(SP_T, 7, 1'b0);
    #1;
    chk("R5 inverted registered output", 32'(pin_out[9]), 32'h1);
    in_i[7] = 1'b1;
    #1;
    chk("R8 preset waits for edge", 32'(pin_out[9]), 32'h1);
    after_edge();
    chk("R8 preset sets inverted cell", 32'(pin_out[9]), 32'h0);
    chk("R8 preset sets plain cell", 32'(pin_out[5]), 32'h1);
    @(negedge clk);
    in_i[7] = 1'b0;
    after_edge();
    chk("R8 release reloads sum", 32'(pin_out[9]), 32'h1);
    chk("R8 release reloads sum plain", 32'(pin_out[5]), 32'h0);
  endtask

  task automatic t_async_clear();
    @(negedge clk);
    clear_term(AR_T);
    lit(AR_T, 8, 1'b0);
    in_i[6] = 1'b1;
    after_edge();
    chk("R9 state set before clear", 32'(pin_out[5]), 32'h1);
    @(negedge clk);
    in_i[8] = 1'b1;
    #1;
    chk("R9 clear without edge", 32'(pin_out[5]), 32'h0);
    @(negedge clk);
    in_i[8] = 1'b0;
    #1;
    chk("R9 held clear after release", 32'(pin_out[5]), 32'h0);
    after_edge();
    chk("R9 reload after release", 32'(pin_out[5]), 32'h1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    in_i[7] = 1'b1;
    in_i[8] = 1'b1;
    after_edge();
    chk("R10 clear beats preset plain", 32'(pin_out[5]), 32'h0);
    chk("R10 clear beats preset inverted", 32'(pin_out[9]), 32'h1);
    @(negedge clk);
    in_i[7] = 1'b0;
    in_i[8] = 1'b0;
    after_edge();
    chk("R10 normal load resumes", 32'(pin_out[5]), 32'h1);
  endtask

  task automatic t_sync_rst();
    @(negedge clk);
    in_i[7] = 1'b1;
    after_edge();
    chk("R11 preset before reset", 32'(pin_out[9]), 32'h0);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R11 reset waits for edge", 32'(pin_out[9]), 32'h0);
    after_edge();
    chk("R11 reset beats preset inverted", 32'(pin_out[9]), 32'h1);
    chk("R11 reset beats sum", 32'(pin_out[5]), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    in_i[7] = 1'b0;
    after_edge();
    chk("R11 load after reset", 32'(pin_out[5]), 32'h1);
  endtask

  initial begin
    t_reset();
    t_and_term();
    t_sum_size();
    t_polarity();
    t_oe();
    t_registered();
    t_feedback();
    t_preset();
    t_async_clear();
    t_priority();
    t_sync_rst();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule